// File: doc/BRIEF.md
# Chip-Spread SEC/DED Memory ECC

This block protects a wide memory access against the loss of a whole 4-bit DRAM device. On the write side, a 256-bit access is cut into four 64-bit words. Each word is encoded into a 72-bit single-error-correcting, double-error-detecting Hamming codeword. The four codewords are interleaved onto 72 four-bit lanes, one lane per device, so that every lane holds exactly one bit of each codeword. When a device dies, each codeword sees at most one bad bit, and all four words are still corrected.

On the read side, the 288 lane bits are de-interleaved and the four codewords are decoded in parallel. The corrected data, a 2-bit status per word and a device-failure indication are captured in a single output register. That register sits behind a valid/ready handshake. The register is run by a two-state machine:
- `RS_EMPTY` moves to `RS_FULL` when a read is accepted.
- `RS_FULL` returns to `RS_EMPTY` when the consumer takes the result and no new read arrives.
- `RS_FULL` stays in `RS_FULL` while the consumer stalls, or when a consume and a new accept happen in the same cycle.

The write path is combinational, and its handshake passes straight through.

Top module: `csx_ecc`

## Requirements
- R1: The write path is combinational. `wr_lanes_valid` equals `wr_valid`, and `wr_ready` equals `wr_lanes_ready`, in every cycle.
- R2: Word w is `wr_data[64w+63:64w]`. It is encoded into codeword w as follows:
  - Position 0 is the even parity of positions 1..71.
  - Position 2^i (i = 0..6) is the XOR of all data positions whose index has bit i set.
  - The 64 data bits fill the remaining positions (3, 5, 6, 7, 9, ...) in ascending order.
  - Lane L, bit b (`wr_lanes[4L+b]`) carries position L of codeword b.
- R3: Reading back unmodified lanes returns the written data, with every word status 00 (clean). Word w's status is `rd_status[2w+1:2w]`.
- R4: A single flipped bit at any position of any one word is corrected. That word reports status 01 (corrected), and the others report 00.
- R5: Two flipped bits in one word give status 10 (uncorrectable) for that word. The other words still return correct data and status 00. Status 11 never occurs.
- R6: Inverting all four bits of any lane L gives status 01 on all four words, `rd_dev_fail` = 1 and `rd_dev_lane` = L. Forcing any lane to zero always returns correct data. A word then reports 01 exactly when its bit in that lane was 1, and 00 otherwise.
- R7: `rd_dev_fail` is 1 only when all four words report 01 at the same position. Single errors in fewer words, or in different lanes, leave it 0.
- R8: A read accepted at a clock edge (`rd_lanes_valid` and `rd_lanes_ready`) makes `rd_valid` high after that edge, carrying that read's result.
- R9: `rd_lanes_ready` = !`rd_valid` || `rd_ready`. While `rd_valid` is high and `rd_ready` is low, all read outputs hold. Results leave in the order they were accepted.
- R10: After reset, `rd_valid` is 0 and `rd_lanes_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Write data accepted |
| wr_data | input | 256 | Four 64-bit data words |
| wr_lanes_valid | output | 1 | Encoded lanes valid |
| wr_lanes_ready | input | 1 | Lane sink ready |
| wr_lanes | output | 288 | 72 four-bit device lanes |
| rd_lanes_valid | input | 1 | Read lanes valid |
| rd_lanes_ready | output | 1 | Read lanes accepted |
| rd_lanes | input | 288 | Lanes returned from memory |
| rd_valid | output | 1 | Decoded result valid |
| rd_ready | input | 1 | Consumer takes the result |
| rd_data | output | 256 | Corrected data |
| rd_status | output | 8 | 2-bit status per word |
| rd_dev_fail | output | 1 | Same-lane error in all four words |
| rd_dev_lane | output | 7 | Lane index of that error |

## Verification
The bench uses the default build: 64-bit words, four words and seven Hamming check bits, which gives 72 lanes and a 7-bit lane index. With these values every lane can be swept by inversion and by forcing to zero. The sweep reaches lane 0, which holds the overall parity bit and so has a zero syndrome. It also reaches the seven power-of-two check lanes and the last lane, 71. Double errors and cross-lane single errors are placed at the extreme positions to separate detection from miscorrection.

// File: rtl/csx_pkg.sv
package csx_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_FATAL = 2'b10
    } word_stat_e;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_FULL  = 1'b1
    } rd_state_e;

    // True when p is a power of two (a Hamming check position).
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Floor of log2 for positive p.
    function automatic int flog2(input int p);
        int r;
        r = 0;
        for (int k = 1; k < 31; k++) begin
            if ((p >> k) != 0) r = k;
        end
        return r;
    endfunction

    // Positions 0..127 whose index has bit i set.
    function automatic logic [127:0] pos_mask(input int i);
        logic [127:0] m;
        for (int p = 0; p < 128; p++) m[p] = ((p >> i) & 1) == 1;
        return m;
    endfunction

endpackage

// File: rtl/csx_word_enc.sv
module csx_word_enc
    import csx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PBITS  = 7,
    localparam int CW_W  = DATA_W + PBITS + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    logic [CW_W-1:1] dbody;
    logic [CW_W-1:1] body;
    logic [PBITS-1:0] chk;

    for (genvar p = 1; p < CW_W; p++) begin : g_pos
        if (is_pow2(p)) begin : g_chk
            assign dbody[p] = 1'b0;
            assign body[p]  = chk[flog2(p)];
        end else begin : g_dat
            assign dbody[p] = data_i[p - 2 - flog2(p)];
            assign body[p]  = dbody[p];
        end
    end

    for (genvar i = 0; i < PBITS; i++) begin : g_par
        localparam logic [127:0] MASK = pos_mask(i);
        assign chk[i] = ^(dbody & MASK[CW_W-1:1]);
    end

    assign cw_o = {body, ^body};

endmodule

// File: rtl/csx_word_dec.sv
module csx_word_dec
    import csx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PBITS  = 7,
    localparam int CW_W  = DATA_W + PBITS + 1
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        stat_o,
    output logic [PBITS-1:0]  pos_o
);

    logic [PBITS-1:0] syn;
    logic             par;
    logic [CW_W-1:0]  flip;
    logic [CW_W-1:0]  fixed;
    word_stat_e       stat;

    for (genvar i = 0; i < PBITS; i++) begin : g_syn
        localparam logic [127:0] MASK = pos_mask(i);
        assign syn[i] = ^(cw_i[CW_W-1:1] & MASK[CW_W-1:1]);
    end

    assign par = ^cw_i;

    always_comb begin
        flip = '0;
        stat = ST_CLEAN;
        if (par) begin
            if (int'(syn) < CW_W) begin
                flip[syn] = 1'b1;
                stat      = ST_FIXED;
            end else begin
                stat = ST_FATAL;
            end
        end else if (syn != '0) begin
            stat = ST_FATAL;
        end
    end

    assign fixed  = cw_i ^ flip;
    assign stat_o = stat;
    assign pos_o  = syn;

    for (genvar p = 1; p < CW_W; p++) begin : g_ext
        if (!is_pow2(p)) begin : g_dat
            assign data_o[p - 2 - flog2(p)] = fixed[p];
        end
    end

endmodule

// File: rtl/csx_rd_stage.sv
module csx_rd_stage
    import csx_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_pay
);

    rd_state_e        st_q;
    rd_state_e        st_d;
    logic             take;
    logic [PAY_W-1:0] pay_q;

    // Output process
    always_comb begin
        out_valid = (st_q == RS_FULL);
        in_ready  = (st_q == RS_EMPTY) || out_ready;
    end

    assign take    = in_valid && in_ready;
    assign out_pay = pay_q;

    // Next-state process
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_EMPTY: if (take) st_d = RS_FULL;
            RS_FULL:  if (out_ready && !take) st_d = RS_EMPTY;
            default:  st_d = RS_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pay_q <= '0;
        else if (take) pay_q <= in_pay;
    end

endmodule

// File: rtl/csx_ecc.sv
module csx_ecc
    import csx_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORDS  = 4,
    parameter int PBITS  = 7,
    localparam int CW_W  = DATA_W + PBITS + 1,
    localparam int BUS_W = CW_W * WORDS,
    localparam int DW    = DATA_W * WORDS,
    localparam int SW    = 2 * WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_lanes_valid,
    input  logic             wr_lanes_ready,
    output logic [BUS_W-1:0] wr_lanes,
    input  logic             rd_lanes_valid,
    output logic             rd_lanes_ready,
    input  logic [BUS_W-1:0] rd_lanes,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [DW-1:0]    rd_data,
    output logic [SW-1:0]    rd_status,
    output logic             rd_dev_fail,
    output logic [PBITS-1:0] rd_dev_lane
);

    localparam int PAY_W = DW + SW + 1 + PBITS;

    logic [CW_W-1:0]   enc_cw [WORDS];
    logic [CW_W-1:0]   dec_cw [WORDS];
    logic [1:0]        w_stat [WORDS];
    logic [PBITS-1:0]  w_pos  [WORDS];
    logic [DW-1:0]     dec_data;
    logic [SW-1:0]     dec_stat;
    logic              dev_fail;
    logic [PAY_W-1:0]  pay_in;
    logic [PAY_W-1:0]  pay_out;

    assign wr_lanes_valid = wr_valid;
    assign wr_ready       = wr_lanes_ready;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        csx_word_enc #(.DATA_W(DATA_W), .PBITS(PBITS)) u_enc (
            .data_i (wr_data[w*DATA_W +: DATA_W]),
            .cw_o   (enc_cw[w])
        );
        csx_word_dec #(.DATA_W(DATA_W), .PBITS(PBITS)) u_dec (
            .cw_i   (dec_cw[w]),
            .data_o (dec_data[w*DATA_W +: DATA_W]),
            .stat_o (w_stat[w]),
            .pos_o  (w_pos[w])
        );
        assign dec_stat[2*w +: 2] = w_stat[w];
        for (genvar l = 0; l < CW_W; l++) begin : g_lane
            assign wr_lanes[l*WORDS + w] = enc_cw[w][l];
            assign dec_cw[w][l]          = rd_lanes[l*WORDS + w];
        end
    end

    always_comb begin
        dev_fail = 1'b1;
        for (int w = 0; w < WORDS; w++) begin
            if (w_stat[w] != ST_FIXED) dev_fail = 1'b0;
            if (w_pos[w] != w_pos[0])  dev_fail = 1'b0;
        end
    end

    assign pay_in = {w_pos[0], dev_fail, dec_stat, dec_data};

    csx_rd_stage #(.PAY_W(PAY_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rd_lanes_valid),
        .in_ready  (rd_lanes_ready),
        .in_pay    (pay_in),
        .out_valid (rd_valid),
        .out_ready (rd_ready),
        .out_pay   (pay_out)
    );

    assign {rd_dev_lane, rd_dev_fail, rd_status, rd_data} = pay_out;

endmodule

// File: rtl/csx_ecc_chk.sv
module csx_ecc_chk #(
    parameter int DW = 256,
    parameter int SW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          wr_lanes_valid,
    input logic          wr_lanes_ready,
    input logic          rd_lanes_valid,
    input logic          rd_lanes_ready,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [DW-1:0] rd_data,
    input logic [SW-1:0] rd_status,
    input logic          rd_dev_fail
);

    // R1
    wr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lanes_valid == wr_valid) && (wr_ready == wr_lanes_ready));

    // R8
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lanes_valid && rd_lanes_ready |=> rd_valid);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)
                                   && $stable(rd_status) && $stable(rd_dev_fail));

    // R9
    rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |-> !rd_lanes_ready);

    // R7
    dev_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_dev_fail |-> rd_status == {(SW/2){2'b01}});

    for (genvar w = 0; w < SW / 2; w++) begin : g_code
        // R5
        no_code11_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> rd_status[2*w +: 2] != 2'b11);
    end

endmodule

bind csx_ecc csx_ecc_chk #(.DW(DW), .SW(SW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_lanes_valid (wr_lanes_valid),
    .wr_lanes_ready (wr_lanes_ready),
    .rd_lanes_valid (rd_lanes_valid),
    .rd_lanes_ready (rd_lanes_ready),
    .rd_valid       (rd_valid),
    .rd_ready       (rd_ready),
    .rd_data        (rd_data),
    .rd_status      (rd_status),
    .rd_dev_fail    (rd_dev_fail)
);

// File: tb/csx_ecc_tb_top.sv
`timescale 1ns/1ps
module csx_ecc_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [255:0] wr_data = '0;
    logic         wr_lanes_valid;
    logic         wr_lanes_ready = 1'b1;
    logic [287:0] wr_lanes;
    logic         rd_lanes_valid = 1'b0;
    logic         rd_lanes_ready;
    logic [287:0] rd_lanes = '0;
    logic         rd_valid;
    logic         rd_ready = 1'b1;
    logic [255:0] rd_data;
    logic [7:0]   rd_status;
    logic         rd_dev_fail;
    logic [6:0]   rd_dev_lane;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    csx_ecc dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_valid       (wr_valid),
        .wr_ready       (wr_ready),
        .wr_data        (wr_data),
        .wr_lanes_valid (wr_lanes_valid),
        .wr_lanes_ready (wr_lanes_ready),
        .wr_lanes       (wr_lanes),
        .rd_lanes_valid (rd_lanes_valid),
        .rd_lanes_ready (rd_lanes_ready),
        .rd_lanes       (rd_lanes),
        .rd_valid       (rd_valid),
        .rd_ready       (rd_ready),
        .rd_data        (rd_data),
        .rd_status      (rd_status),
        .rd_dev_fail    (rd_dev_fail),
        .rd_dev_lane    (rd_dev_lane)
    );

    // Reference codeword built from the R2 layout.
    function automatic logic [71:0] ref_cw(input logic [63:0] d);
        logic [71:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < 72; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int i = 0; i < 7; i++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < 72; p++) begin
                if (((p & (p - 1)) != 0) && (((p >> i) & 1) == 1)) x = x ^ c[p];
            end
            c[1 << i] = x;
        end
        c[0] = ^c[71:1];
        return c;
    endfunction

    function automatic logic [287:0] ref_lanes(input logic [255:0] d);
        logic [287:0] s;
        s = '0;
        for (int w = 0; w < 4; w++) begin
            logic [71:0] c;
            c = ref_cw(d[64*w +: 64]);
            for (int l = 0; l < 72; l++) s[4*l + w] = c[l];
        end
        return s;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [287:0] act, input logic [287:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one read; the result is sampled at the negedge after acceptance.
    task automatic issue_read(input logic [287:0] lanes);
        @(negedge clk);
        rd_lanes       = lanes;
        rd_lanes_valid = 1'b1;
        @(negedge clk);
        rd_lanes_valid = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [255:0] ed,
                          input logic [255:0] dmask, input logic [7:0] es,
                          input bit ef, input logic [6:0] el);
        chk(rd_valid === 1'b1, req, rd_valid, 1);
        chk(((rd_data ^ ed) & dmask) == '0, req, rd_data & dmask, ed & dmask);
        chk(rd_status === es, req, rd_status, es);
        chk(rd_dev_fail === ef, req, rd_dev_fail, ef);
        if (ef) chk(rd_dev_lane === el, req, rd_dev_lane, el);
    endtask

    task automatic t_reset();
        // R10
        chk(rd_valid === 1'b0, "R10 rd_valid", rd_valid, 0);
        chk(rd_lanes_ready === 1'b1, "R10 rd_lanes_ready", rd_lanes_ready, 1);
    endtask

    task automatic t_write_map();
        logic [255:0] pats [4];
        pats[0] = '0;
        pats[1] = '1;
        pats[2] = {32{8'hA5}};
        pats[3] = rnd256();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            wr_data        = pats[i];
            wr_valid       = 1'b1;
            wr_lanes_ready = (i % 2) == 0;
            #1;
            // R2
            chk(wr_lanes === ref_lanes(pats[i]), "R2 lane map", wr_lanes, ref_lanes(pats[i]));
            // R1
            chk(wr_lanes_valid === 1'b1, "R1 valid pass", wr_lanes_valid, 1);
            chk(wr_ready === wr_lanes_ready, "R1 ready pass", wr_ready, wr_lanes_ready);
        end
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        chk(wr_lanes_valid === 1'b0, "R1 valid low", wr_lanes_valid, 0);
    endtask

    task automatic t_clean();
        for (int i = 0; i < 4; i++) begin
            logic [255:0] d;
            d = (i == 0) ? '1 : rnd256();
            issue_read(ref_lanes(d));
            // R3 R8
            chk_rd("R3 clean", d, '1, 8'h00, 1'b0, '0);
        end
    endtask

    task automatic t_single();
        int pos [6] = '{0, 1, 3, 64, 70, 71};
        logic [255:0] d;
        d = rnd256();
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 6; k++) begin
                issue_read(ref_lanes(d) ^ (288'b1 << (4*pos[k] + w)));
                // R4
                chk_rd("R4 single", d, '1, 8'h01 << (2*w), 1'b0, '0);
            end
        end
    endtask

    task automatic t_lane_sweep();
        for (int j = 0; j < 2; j++) begin
            logic [255:0] d;
            logic [287:0] s;
            d = (j == 0) ? rnd256() : '1;
            s = ref_lanes(d);
            for (int l = 0; l < 72; l++) begin
                logic [7:0] es;
                bit ef;
                issue_read(s ^ (288'hF << (4*l)));
                // R6 inverted lane
                chk_rd("R6 lane invert", d, '1, 8'h55, 1'b1, 7'(l));
                es = '0;
                ef = 1'b1;
                for (int w = 0; w < 4; w++) begin
                    es[2*w +: 2] = s[4*l + w] ? 2'b01 : 2'b00;
                    if (!s[4*l + w]) ef = 1'b0;
                end
                issue_read(s & ~(288'hF << (4*l)));
                // R6 zeroed lane
                chk_rd("R6 lane zero", d, '1, es, ef, 7'(l));
            end
        end
    endtask

    task automatic t_double();
        int pa [3] = '{5, 0, 3};
        int pb [3] = '{9, 71, 64};
        logic [255:0] d;
        logic [255:0] keep;
        d = rnd256();
        keep = ~(256'hFFFF_FFFF_FFFF_FFFF << 128);
        for (int k = 0; k < 3; k++) begin
            issue_read(ref_lanes(d) ^ (288'b1 << (4*pa[k] + 2)) ^ (288'b1 << (4*pb[k] + 2)));
            // R5
            chk_rd("R5 double", d, keep, 8'h20, 1'b0, '0);
        end
    endtask

    task automatic t_no_dev_fail();
        logic [255:0] d;
        logic [287:0] s;
        d = rnd256();
        s = ref_lanes(d);
        issue_read(s ^ (288'b1 << (4*5 + 0)) ^ (288'b1 << (4*9 + 1)));
        // R7 two words, different lanes
        chk_rd("R7 two words", d, '1, 8'h05, 1'b0, '0);
        issue_read(s ^ (288'b1 << (4*10 + 0)) ^ (288'b1 << (4*10 + 1)) ^ (288'b1 << (4*10 + 2)));
        // R7 three words, same lane
        chk_rd("R7 three words", d, '1, 8'h15, 1'b0, '0);
        issue_read(s ^ (288'b1 << 0) ^ (288'b1 << (4*1 + 1))
                     ^ (288'b1 << (4*2 + 2)) ^ (288'b1 << (4*3 + 3)));
        // R7 four words, different lanes
        chk_rd("R7 four lanes", d, '1, 8'h55, 1'b0, '0);
    endtask

    task automatic t_backpressure();
        logic [255:0] a;
        logic [255:0] b;
        a = rnd256();
        b = rnd256();
        @(negedge clk);
        rd_ready       = 1'b0;
        rd_lanes       = ref_lanes(a);
        rd_lanes_valid = 1'b1;
        @(negedge clk);
        rd_lanes = ref_lanes(b);
        // R8
        chk_rd("R8 first", a, '1, 8'h00, 1'b0, '0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R9 hold
            chk(rd_lanes_ready === 1'b0, "R9 not ready", rd_lanes_ready, 0);
            chk(rd_data === a, "R9 hold data", rd_data, a);
            chk(rd_valid === 1'b1, "R9 hold valid", rd_valid, 1);
        end
        rd_ready = 1'b1;
        @(negedge clk);
        rd_lanes_valid = 1'b0;
        // R9 order
        chk(rd_data === b, "R9 second result", rd_data, b);
        chk(rd_valid === 1'b1, "R9 second valid", rd_valid, 1);
        @(negedge clk);
        chk(rd_valid === 1'b0, "R9 drained", rd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_map();
        t_clean();
        t_single();
        t_lane_sweep();
        t_double();
        t_no_dev_fail();
        t_backpressure();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule